// File: doc/BRIEF.md
# Epoch-Tagged Fetch and Redirect Controller

This block is the front-end control of a short in-order pipeline. It holds the fetch address and, each cycle, does one of two things. If a redirect is pending, it loads the redirect target into the fetch address, flips its fetch epoch bit and consumes the redirect. Otherwise it tries to issue the instruction at the current address into a single-entry buffer that feeds the execute stage. The fetch address moves to the predicted successor, which is the address plus four, only in a cycle where an issue actually happens. A hazard on either source operand holds the address, and so does a full buffer.

Every issued entry carries its address, the predicted next address, the decoded instruction word, both operand values and the fetch epoch bit that was current at issue. The execute side of the block keeps its own epoch bit. An entry is live only if its tag matches that bit. When a live entry is taken with a misprediction flag, the execute epoch flips and the correct target is posted as a pending redirect. The fetch side consumes that redirect one cycle later. Entries issued before the redirect is consumed carry the old tag. They are taken as stale and have no effect, but each one still signals that its scoreboard slot is released.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: After a synchronous reset, fetch_pc equals the RESET_PC parameter (default 0x100), fetch_tag, exec_tag and redir_pend are 0, and ex_vld is 0.
- R2: When no redirect is pending, neither hazard input is high and the buffer can accept an entry, issue_fire is high in that cycle and fetch_pc is fetch_pc+4 after the next clock edge.
- R3: An issued entry shows on the ex_* outputs after the clock edge: ex_pc is the issuing address, ex_ppc is that address plus 4, ex_tag is fetch_tag at issue, and ex_word, ex_opa and ex_opb are the values presented at issue.
- R4: If haz_src_a or haz_src_b is high, issue_fire is low and fetch_pc is unchanged after the edge.
- R5: The buffer can accept an entry when it is empty or when ex_take is high in the same cycle. If the buffer holds an entry and ex_take is low, issue_fire is low and both fetch_pc and the entry stay unchanged.
- R6: When a live entry is taken with ex_mispredict high, redir_pend is 1 after the edge and exec_tag is inverted.
- R7: While redir_pend is 1, issue_fire is low whatever the other inputs are. After the next edge, fetch_pc equals the posted target, fetch_tag is inverted and redir_pend is 0.
- R8: ex_live is high exactly when ex_vld is high and ex_tag equals exec_tag. Taking a stale entry with ex_mispredict high changes neither exec_tag nor redir_pend.
- R9: slot_release is high in every cycle in which a valid entry is taken, whether the entry is live or stale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | 32 | Current fetch address |
| fetch_tag | output | 1 | Fetch epoch bit |
| dec_word | input | 32 | Decoded instruction at fetch_pc |
| opnd_a | input | 32 | First operand value |
| opnd_b | input | 32 | Second operand value |
| haz_src_a | input | 1 | Hazard on the first source register |
| haz_src_b | input | 1 | Hazard on the second source register |
| issue_fire | output | 1 | The entry is enqueued in this cycle |
| ex_vld | output | 1 | The buffer holds an entry |
| ex_live | output | 1 | The held entry matches the execute epoch |
| ex_pc | output | 32 | Address of the held entry |
| ex_ppc | output | 32 | Predicted next address of the held entry |
| ex_tag | output | 1 | Epoch tag of the held entry |
| ex_word | output | 32 | Instruction word of the held entry |
| ex_opa | output | 32 | First operand of the held entry |
| ex_opb | output | 32 | Second operand of the held entry |
| ex_take | input | 1 | Execute consumes the held entry |
| ex_mispredict | input | 1 | The taken entry was mispredicted |
| ex_target | input | 32 | Correct address for a misprediction |
| slot_release | output | 1 | Scoreboard slot freed in this cycle |
| redir_pend | output | 1 | A redirect is waiting for fetch |
| exec_tag | output | 1 | Execute epoch bit |

## Verification
Two pairs of events can happen in the same cycle. The first is the execute side draining the buffer while fetch enqueues into it. The bench provokes this by raising ex_take while the buffer is full. It expects issue_fire high and slot_release high together, with the new entry replacing the old one after the edge. The second is a pending redirect being consumed while the buffer is free and a stale entry is taken with its own misprediction flag. There the bench expects no issue, the fetch address at the first target, and no second epoch flip or redirect.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] ppc;
    logic              tag;
    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
  } d2e_t;
endpackage

// File: rtl/fr_pc_unit.sv
module fr_pc_unit #(
  parameter int unsigned AW       = 32,
  parameter logic [AW-1:0] RESET_PC = 'h100,
  parameter int unsigned STEP     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redir_pend,
  input  logic [AW-1:0] redir_addr,
  input  logic          haz_a,
  input  logic          haz_b,
  input  logic          can_enq,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ppc,
  output logic          tag,
  output logic          issue_fire,
  output logic          redir_take
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] pc_q;
  logic          tag_q;

  assign redir_take = redir_pend;
  assign issue_fire = !redir_pend && !haz_a && !haz_b && can_enq;
  assign ppc        = pc_q + STEP_V;
  assign pc         = pc_q;
  assign tag        = tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      tag_q <= 1'b0;
    end else if (redir_take) begin
      pc_q  <= redir_addr;
      tag_q <= ~tag_q;
    end else if (issue_fire) begin
      pc_q  <= ppc;
    end
  end

  // R2
  pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
    issue_fire |=> pc_q == $past(pc_q) + STEP_V);

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!issue_fire && !redir_take) |=> $stable(pc_q) && $stable(tag_q));

  // R7
  redir_flip_chk: assert property (@(posedge clk) disable iff (rst)
    redir_take |=> (tag_q != $past(tag_q)) && (pc_q == $past(redir_addr)));
endmodule

// File: rtl/fr_d2e_buf.sv
module fr_d2e_buf
  import fr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enq,
  input  d2e_t enq_data,
  input  logic deq,
  output logic vld,
  output d2e_t head
);
  logic vld_q;
  d2e_t data_q;

  always_ff @(posedge clk) begin
    if (rst)          vld_q <= 1'b0;
    else if (enq)     vld_q <= 1'b1;
    else if (deq)     vld_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (enq) data_q <= enq_data;
  end

  assign vld  = vld_q;
  assign head = data_q;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(vld_q && !deq && enq));

  // R5
  hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !deq) |=> vld_q && $stable(data_q));
endmodule

// File: rtl/fr_exec_epoch.sv
module fr_exec_epoch #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          head_vld,
  input  logic          head_tag,
  input  logic          take,
  input  logic          mispredict,
  input  logic [AW-1:0] target,
  input  logic          redir_take,
  output logic          live,
  output logic          etag,
  output logic          redir_pend,
  output logic [AW-1:0] redir_addr,
  output logic          slot_release
);
  logic          etag_q;
  logic          rp_q;
  logic [AW-1:0] ra_q;
  logic          misp_fire;

  assign live         = head_vld && (head_tag == etag_q);
  assign misp_fire    = take && live && mispredict;
  assign slot_release = take && head_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      etag_q <= 1'b0;
      rp_q   <= 1'b0;
    end else begin
      if (misp_fire) etag_q <= ~etag_q;
      if (misp_fire)       rp_q <= 1'b1;
      else if (redir_take) rp_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (misp_fire) ra_q <= target;
  end

  assign etag       = etag_q;
  assign redir_pend = rp_q;
  assign redir_addr = ra_q;

  // R6
  misp_post_chk: assert property (@(posedge clk) disable iff (rst)
    misp_fire |=> rp_q && (etag_q != $past(etag_q)));

  // R8
  stale_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (take && head_vld && !live) |=> $stable(etag_q));

  // R6
  single_redir_chk: assert property (@(posedge clk) disable iff (rst)
    !(rp_q && misp_fire));
endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl
  import fr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 'h100,
  parameter int unsigned       STEP     = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              fetch_tag,
  input  logic [WORD_W-1:0] dec_word,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              haz_src_a,
  input  logic              haz_src_b,
  output logic              issue_fire,
  output logic              ex_vld,
  output logic              ex_live,
  output logic [ADDR_W-1:0] ex_pc,
  output logic [ADDR_W-1:0] ex_ppc,
  output logic              ex_tag,
  output logic [WORD_W-1:0] ex_word,
  output logic [DATA_W-1:0] ex_opa,
  output logic [DATA_W-1:0] ex_opb,
  input  logic              ex_take,
  input  logic              ex_mispredict,
  input  logic [ADDR_W-1:0] ex_target,
  output logic              slot_release,
  output logic              redir_pend,
  output logic              exec_tag
);
  logic [ADDR_W-1:0] pc_w, ppc_w, raddr_w;
  logic              ftag_w, rpend_w, rtake_w, fire_w, can_enq_w, hvld_w, deq_w;
  d2e_t              enq_d, head_d;

  assign deq_w     = ex_take && hvld_w;
  assign can_enq_w = !hvld_w || deq_w;

  fr_pc_unit #(.AW(ADDR_W), .RESET_PC(RESET_PC), .STEP(STEP)) pc_i (
    .clk, .rst,
    .redir_pend(rpend_w), .redir_addr(raddr_w),
    .haz_a(haz_src_a), .haz_b(haz_src_b), .can_enq(can_enq_w),
    .pc(pc_w), .ppc(ppc_w), .tag(ftag_w),
    .issue_fire(fire_w), .redir_take(rtake_w)
  );

  always_comb begin
    enq_d.pc   = pc_w;
    enq_d.ppc  = ppc_w;
    enq_d.tag  = ftag_w;
    enq_d.word = dec_word;
    enq_d.opa  = opnd_a;
    enq_d.opb  = opnd_b;
  end

  fr_d2e_buf buf_i (
    .clk, .rst, .enq(fire_w), .enq_data(enq_d),
    .deq(deq_w), .vld(hvld_w), .head(head_d)
  );

  fr_exec_epoch #(.AW(ADDR_W)) ex_i (
    .clk, .rst,
    .head_vld(hvld_w), .head_tag(head_d.tag),
    .take(ex_take), .mispredict(ex_mispredict), .target(ex_target),
    .redir_take(rtake_w),
    .live(ex_live), .etag(exec_tag),
    .redir_pend(rpend_w), .redir_addr(raddr_w),
    .slot_release(slot_release)
  );

  assign fetch_pc   = pc_w;
  assign fetch_tag  = ftag_w;
  assign issue_fire = fire_w;
  assign ex_vld     = hvld_w;
  assign ex_pc      = head_d.pc;
  assign ex_ppc     = head_d.ppc;
  assign ex_tag     = head_d.tag;
  assign ex_word    = head_d.word;
  assign ex_opa     = head_d.opa;
  assign ex_opb     = head_d.opb;
  assign redir_pend = rpend_w;

  // R8
  live_match_chk: assert property (@(posedge clk) disable iff (rst)
    ex_live |-> ex_vld && (ex_tag == exec_tag));
endmodule

// File: tb/fetch_redirect_ctrl_tb_top.sv
module fetch_redirect_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc, ex_pc, ex_ppc, ex_word, ex_opa, ex_opb;
  logic        fetch_tag, issue_fire, ex_vld, ex_live, ex_tag;
  logic        slot_release, redir_pend, exec_tag;
  logic [31:0] dec_word = '0, opnd_a = '0, opnd_b = '0, ex_target = '0;
  logic        haz_src_a = 0, haz_src_b = 0, ex_take = 0, ex_mispredict = 0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  fetch_redirect_ctrl dut_i (
    .clk, .rst, .fetch_pc, .fetch_tag, .dec_word, .opnd_a, .opnd_b,
    .haz_src_a, .haz_src_b, .issue_fire, .ex_vld, .ex_live, .ex_pc,
    .ex_ppc, .ex_tag, .ex_word, .ex_opa, .ex_opb, .ex_take,
    .ex_mispredict, .ex_target, .slot_release, .redir_pend, .exec_tag
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1 pc", fetch_pc, 32'h100);
    check("R1 ftag", 32'(fetch_tag), 0);
    check("R1 etag", 32'(exec_tag), 0);
    check("R1 redir", 32'(redir_pend), 0);
    check("R1 vld", 32'(ex_vld), 0);
  endtask

  task automatic t_issue;
    dec_word = 32'hA5A5_0001; opnd_a = 32'h11; opnd_b = 32'h22;
    #2 check("R2 fire", 32'(issue_fire), 1);
    @(negedge clk);
    check("R2 pc", fetch_pc, 32'h104);
    check("R3 pc", ex_pc, 32'h100);
    check("R3 ppc", ex_ppc, 32'h104);
    check("R3 tag", 32'(ex_tag), 0);
    check("R3 word", ex_word, 32'hA5A5_0001);
    check("R3 opa", ex_opa, 32'h11);
    check("R3 opb", ex_opb, 32'h22);
    check("R8 live", 32'(ex_live), 1);
  endtask

  task automatic t_full;
    dec_word = 32'hB6B6_0002;
    #2 check("R5 blocked", 32'(issue_fire), 0);
    @(negedge clk);
    check("R5 pc held", fetch_pc, 32'h104);
    check("R5 entry held", ex_pc, 32'h100);
  endtask

  task automatic t_take_issue;
    ex_take = 1;
    #2 check("R5 drain fire", 32'(issue_fire), 1);
    check("R9 release", 32'(slot_release), 1);
    @(negedge clk);
    ex_take = 0;
    check("R2 pc", fetch_pc, 32'h108);
    check("R5 new entry", ex_pc, 32'h104);
    check("R3 word", ex_word, 32'hB6B6_0002);
  endtask

  task automatic t_hazard;
    haz_src_a = 1; ex_take = 1;
    #2 check("R4 haz a", 32'(issue_fire), 0);
    @(negedge clk);
    ex_take = 0; haz_src_a = 0; haz_src_b = 1;
    check("R4 pc held a", fetch_pc, 32'h108);
    check("R4 empty", 32'(ex_vld), 0);
    #2 check("R4 haz b", 32'(issue_fire), 0);
    @(negedge clk);
    haz_src_b = 0;
    check("R4 pc held b", fetch_pc, 32'h108);
  endtask

  task automatic t_redirect;
    @(negedge clk);
    check("R2 pc", fetch_pc, 32'h10C);
    ex_take = 1; ex_mispredict = 1; ex_target = 32'h200;
    #2 check("R5 drain fire", 32'(issue_fire), 1);
    @(negedge clk);
    check("R6 pend", 32'(redir_pend), 1);
    check("R6 etag", 32'(exec_tag), 1);
    check("R3 wrong path", ex_pc, 32'h10C);
    check("R8 stale", 32'(ex_live), 0);
    ex_target = 32'h300;
    #2 check("R7 no issue", 32'(issue_fire), 0);
    check("R9 stale release", 32'(slot_release), 1);
    @(negedge clk);
    ex_take = 0; ex_mispredict = 0;
    check("R7 pc", fetch_pc, 32'h200);
    check("R7 ftag", 32'(fetch_tag), 1);
    check("R7 pend clear", 32'(redir_pend), 0);
    check("R8 etag kept", 32'(exec_tag), 1);
    check("R8 empty", 32'(ex_vld), 0);
    @(negedge clk);
    check("R3 new tag", 32'(ex_tag), 1);
    check("R8 live", 32'(ex_live), 1);
    check("R2 pc", fetch_pc, 32'h204);
  endtask

  initial begin
    t_reset;
    t_issue;
    t_full;
    t_take_issue;
    t_hazard;
    t_redirect;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule